// File: doc/BRIEF.md
# Power-Supply Management Command Responder

This block sits behind the bit-level target logic of a two-wire management bus on a power-supply controller. It receives one-cycle transaction events from that front end: a write transaction has begun, a read transaction has begun, the transaction was closed (by a not-acknowledge or a stop), a data byte arrived from the host, and the host wants the next byte. From these events it tracks a command pointer, accepts configuration writes, and serves read data.

Each write transaction carries a command byte first and data bytes after it. Data bytes land in a 32-byte staging buffer. Only the system-configuration command (0xDA) keeps a value. When a read transaction begins, the block loads the front of the staging buffer with the response for the current command. Depending on the command, that response is a length-prefixed ASCII string, a two-byte identity code, one byte of a firmware version, a fixed zero, or the stored register byte. Read requests then walk the buffer one byte at a time. Buffer positions beyond the loaded response still hold whatever they held before. Once the walk passes the end of the buffer, every further byte is 0xFF.

Top module: `pmbus_psu_responder`

## Requirements
- R1: After reset the pointer is 0xFF, the configuration byte is 0x00, no read is open, and `byte_out_valid_o` is low. A read opened straight after reset therefore returns 0x00.
- R2: The first data byte after a write start (byte count zero) becomes the pointer. A write start or a close sets the pointer to 0xFF and clears the byte count.
- R3: Only command 0xDA is writable. After each data byte of a 0xDA write, the configuration byte takes staging position 0, which is the first data byte. Data written under any other command leaves it unchanged.
- R4: A byte request produces `byte_out_valid_o` high, with the byte on `byte_out_o`, in the next cycle. With no request, valid stays low.
- R5: Within an open read, request k (k = 0, 1, ...) returns staging position k while k < 32, and returns 0xFF from k = 32 on.
- R6: A read start under 0x9A loads 7 followed by "FRU0123". Under 0x9B it loads 7 followed by "PAR0123". Under 0x9E it loads 6 followed by "XYZ012".
- R7: A read start under 0xBD loads 0x2B then 0x1D.
- R8: A read start under 0xFA, 0xFB, 0xFC or 0xFD loads a single byte of 0x04030201. 0xFA gives 0x04 and 0xFD gives 0x01.
- R9: A read start under 0xD6 loads a single 0x00. Under 0xDA it loads the configuration byte. Under every other command it loads 0x00.
- R10: The j-th data byte of a write (j = 1..32) goes to staging position j−1. A read start overwrites only the positions its response uses, so later requests return the leftovers.
- R11: Data bytes after the 32nd are dropped while the count keeps rising, and the count saturates without wrapping. A byte request while no read is open returns 0xFF.
- R12: Events in one cycle resolve by priority: read start, then write start, then close, then data byte, then byte request. Lower-priority events in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_write_i | input | 1 | A write transaction addressed to this target began |
| start_read_i | input | 1 | A read transaction addressed to this target began |
| close_i | input | 1 | The transaction ended with a not-acknowledge or a stop |
| byte_in_valid_i | input | 1 | A byte from the host is on `byte_in_i` |
| byte_in_i | input | 8 | Byte received from the host |
| byte_out_req_i | input | 1 | The front end wants the next read byte |
| byte_out_o | output | 8 | Byte to send to the host |
| byte_out_valid_o | output | 1 | `byte_out_o` holds a new answer this cycle |

## Verification
A pointer left at the wrong value only becomes visible at the next read start. The first answer after that start then carries the wrong content: the wrong string, code or register byte, one cycle after the first request. A byte counter that drifts shows up as a shifted stream, or as 0xFF arriving too early or too late in a long read, or as leftovers in the wrong positions. A corrupted configuration byte stays hidden until a read under 0xDA, so the bench reads it back after every write under that command and after writes under other commands.

// File: rtl/pmbus_rsp_pkg.sv
// Shared constants, types and event arbitration for the command responder.
package pmbus_rsp_pkg;

    typedef logic [7:0] byte_t;

    // Event chosen in a cycle after priority resolution.
    typedef enum logic [2:0] {
        EV_NONE,
        EV_READ_START,
        EV_WRITE_START,
        EV_CLOSE,
        EV_DATA_IN,
        EV_DATA_OUT
    } ev_kind_e;

    // Command codes whose behaviour is fixed.
    localparam byte_t CMD_MODEL    = 8'h9A;
    localparam byte_t CMD_REVISION = 8'h9B;
    localparam byte_t CMD_SERIAL   = 8'h9E;
    localparam byte_t CMD_IDENT    = 8'hBD;
    localparam byte_t CMD_HISTORY  = 8'hD6;
    localparam byte_t CMD_CONFIG   = 8'hDA;
    localparam byte_t CMD_FW_BASE  = 8'hFA;
    localparam byte_t PTR_IDLE     = 8'hFF;
    localparam byte_t FILL_BYTE    = 8'hFF;

    // Largest response loaded at a read start (count byte plus 7 characters).
    localparam int MAX_LOAD = 8;

    localparam logic [55:0] MODEL_TEXT    = "FRU0123";
    localparam logic [55:0] REVISION_TEXT = "PAR0123";
    localparam logic [47:0] SERIAL_TEXT   = "XYZ012";

    // Resolve simultaneous events to one, highest priority first.
    function automatic ev_kind_e pick_event(input logic rd_start, input logic wr_start,
                                            input logic close, input logic data_in,
                                            input logic data_out);
        if (rd_start)      return EV_READ_START;
        else if (wr_start) return EV_WRITE_START;
        else if (close)    return EV_CLOSE;
        else if (data_in)  return EV_DATA_IN;
        else if (data_out) return EV_DATA_OUT;
        else               return EV_NONE;
    endfunction

endpackage

// File: rtl/pmbus_rsp_cmd_decode.sv
// Response composer: given the command pointer and the configuration byte,
// produces the bytes to load into the staging buffer at a read start, and how many.
// Assumes MAX_LOAD >= 8 and that the firmware window does not run past 0xFF.
module pmbus_rsp_cmd_decode
    import pmbus_rsp_pkg::*;
#(
    parameter int FW_BYTES = 4,
    parameter logic [8*FW_BYTES-1:0] FW_VERSION = 32'h04030201,
    parameter logic [15:0] IDENT_CODE = 16'h2B1D,
    localparam int LEN_W = $clog2(MAX_LOAD + 1),
    localparam int FW_W  = 8 * FW_BYTES
) (
    input  byte_t                      ptr_i,
    input  byte_t                      cfg_i,
    output byte_t [MAX_LOAD-1:0]       load_bytes_o,
    output logic  [LEN_W-1:0]          load_len_o
);

    localparam byte_t FW_LAST = CMD_FW_BASE + 8'(FW_BYTES - 1);

    logic          in_fw;
    byte_t         fw_off;
    byte_t         fw_shift;
    logic [FW_W-1:0] fw_shifted;

    // Locate the firmware byte selected by the pointer, most significant first.
    always_comb begin
        in_fw      = (ptr_i >= CMD_FW_BASE) && (ptr_i <= FW_LAST);
        fw_off     = ptr_i - CMD_FW_BASE;
        fw_shift   = 8'(FW_BYTES - 1) - fw_off;
        fw_shifted = FW_VERSION >> {fw_shift, 3'b000};
    end

    // Compose the response bytes for the current command.
    always_comb begin
        load_bytes_o = '0;
        load_len_o   = LEN_W'(1);
        if (ptr_i == CMD_MODEL) begin
            load_bytes_o[0] = 8'd7;
            for (int i = 0; i < 7; i++) load_bytes_o[i+1] = MODEL_TEXT[8*(6-i) +: 8];
            load_len_o = LEN_W'(8);
        end else if (ptr_i == CMD_REVISION) begin
            load_bytes_o[0] = 8'd7;
            for (int i = 0; i < 7; i++) load_bytes_o[i+1] = REVISION_TEXT[8*(6-i) +: 8];
            load_len_o = LEN_W'(8);
        end else if (ptr_i == CMD_SERIAL) begin
            load_bytes_o[0] = 8'd6;
            for (int i = 0; i < 6; i++) load_bytes_o[i+1] = SERIAL_TEXT[8*(5-i) +: 8];
            load_len_o = LEN_W'(7);
        end else if (ptr_i == CMD_IDENT) begin
            load_bytes_o[0] = IDENT_CODE[15:8];
            load_bytes_o[1] = IDENT_CODE[7:0];
            load_len_o      = LEN_W'(2);
        end else if (in_fw) begin
            load_bytes_o[0] = fw_shifted[7:0];
        end else if (ptr_i == CMD_HISTORY) begin
            load_bytes_o[0] = 8'h00;
        end else if (ptr_i == CMD_CONFIG) begin
            load_bytes_o[0] = cfg_i;
        end else begin
            load_bytes_o[0] = 8'h00;
        end
    end

endmodule

// File: rtl/pmbus_rsp_buffer.sv
// Staging buffer: DEPTH bytes. A read start loads the first load_len positions
// at once; a host data byte writes one position. Assumes the two never coincide
// and that DEPTH >= MAX_LOAD.
module pmbus_rsp_buffer
    import pmbus_rsp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(MAX_LOAD + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en_i,
    input  byte_t [MAX_LOAD-1:0]  load_bytes_i,
    input  logic  [LEN_W-1:0]     load_len_i,
    input  logic                  wr_en_i,
    input  logic  [IDX_W-1:0]     wr_idx_i,
    input  byte_t                 wr_data_i,
    input  logic  [IDX_W-1:0]     rd_idx_i,
    output byte_t                 rd_byte_o,
    output byte_t                 head_o
);

    byte_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g < MAX_LOAD) begin : g_loadable
            // Slot reachable by the response load as well as by host writes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[g] <= 8'h00;
                else if (load_en_i && (load_len_i > LEN_W'(g)))
                    slot_q[g] <= load_bytes_i[g];
                else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                    slot_q[g] <= wr_data_i;
            end
        end else begin : g_plain
            // Slot reachable only by host writes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[g] <= 8'h00;
                else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                    slot_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_byte_o = slot_q[rd_idx_i];
    assign head_o    = slot_q[0];

endmodule

// File: rtl/pmbus_rsp_ctrl.sv
// Transaction control: resolves events by priority, keeps the pointer, the
// shared byte counter, the open-read flag and the configuration byte, steers
// the staging buffer and registers the outgoing byte.
module pmbus_rsp_ctrl
    import pmbus_rsp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_write_i,
    input  logic               start_read_i,
    input  logic               close_i,
    input  logic               byte_in_valid_i,
    input  byte_t              byte_in_i,
    input  logic               byte_out_req_i,
    input  byte_t              rd_byte_i,
    input  byte_t              head_i,
    output byte_t              ptr_o,
    output byte_t              cfg_o,
    output logic               load_en_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               reading_o,
    output byte_t              byte_out_o,
    output logic               byte_out_valid_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(DEPTH + 1);

    ev_kind_e         ev;
    byte_t            ptr_q;
    byte_t            cfg_q;
    logic [CNT_W-1:0] count_q;
    logic             reading_q;
    logic             can_serve;

    // Pick this cycle's single event and derive buffer steering.
    always_comb begin
        ev        = pick_event(start_read_i, start_write_i, close_i,
                               byte_in_valid_i, byte_out_req_i);
        load_en_o = (ev == EV_READ_START);
        wr_en_o   = (ev == EV_DATA_IN) && (count_q != '0) && (count_q <= CNT_FULL);
        wr_idx_o  = IDX_W'(count_q - CNT_ONE);
        rd_idx_o  = count_q[IDX_W-1:0];
        can_serve = reading_q && (count_q < CNT_FULL);
    end

    // Command pointer: latched from the first data byte, parked at 0xFF on write start or close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= PTR_IDLE;
        else if (ev == EV_WRITE_START || ev == EV_CLOSE)
            ptr_q <= PTR_IDLE;
        else if (ev == EV_DATA_IN && count_q == '0)
            ptr_q <= byte_in_i;
    end

    // Shared byte counter: cleared by every transaction event, saturating on host bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (ev == EV_READ_START || ev == EV_WRITE_START || ev == EV_CLOSE)
            count_q <= '0;
        else if (ev == EV_DATA_IN && count_q != CNT_CAP)
            count_q <= count_q + CNT_ONE;
        else if (ev == EV_DATA_OUT && can_serve)
            count_q <= count_q + CNT_ONE;
    end

    // Open-read flag: set by a read start, dropped by a write start or close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reading_q <= 1'b0;
        else if (ev == EV_READ_START)
            reading_q <= 1'b1;
        else if (ev == EV_WRITE_START || ev == EV_CLOSE)
            reading_q <= 1'b0;
    end

    // Configuration byte: after each data byte under the config command, copy staging position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= 8'h00;
        else if (ev == EV_DATA_IN && count_q != '0 && ptr_q == CMD_CONFIG)
            cfg_q <= (count_q == CNT_ONE) ? byte_in_i : head_i;
    end

    // Outgoing byte: next staged byte while the read has room, filler otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out_o       <= 8'h00;
            byte_out_valid_o <= 1'b0;
        end else begin
            byte_out_valid_o <= (ev == EV_DATA_OUT);
            if (ev == EV_DATA_OUT)
                byte_out_o <= can_serve ? rd_byte_i : FILL_BYTE;
        end
    end

    assign ptr_o     = ptr_q;
    assign cfg_o     = cfg_q;
    assign count_o   = count_q;
    assign reading_o = reading_q;

endmodule

// File: rtl/pmbus_psu_responder.sv
// Top of the command responder. Assumes the bit-level front end delivers
// one-cycle event strobes synchronous to clk; byte answers follow requests by one cycle.
module pmbus_psu_responder
    import pmbus_rsp_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int FW_BYTES = 4,
    parameter logic [8*FW_BYTES-1:0] FW_VERSION = 32'h04030201,
    parameter logic [15:0] IDENT_CODE = 16'h2B1D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_write_i,
    input  logic       start_read_i,
    input  logic       close_i,
    input  logic       byte_in_valid_i,
    input  logic [7:0] byte_in_i,
    input  logic       byte_out_req_i,
    output logic [7:0] byte_out_o,
    output logic       byte_out_valid_o
);

    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam int CNT_W = $clog2(BUF_DEPTH + 2);
    localparam int LEN_W = $clog2(MAX_LOAD + 1);

    byte_t                ptr_q;
    byte_t                cfg_q;
    logic [CNT_W-1:0]     count_q;
    logic                 reading_q;
    logic                 load_en;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [IDX_W-1:0]     rd_idx;
    byte_t                rd_byte;
    byte_t                head_byte;
    byte_t [MAX_LOAD-1:0] load_bytes;
    logic  [LEN_W-1:0]    load_len;

    pmbus_rsp_ctrl #(.DEPTH(BUF_DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_write_i   (start_write_i),
        .start_read_i    (start_read_i),
        .close_i         (close_i),
        .byte_in_valid_i (byte_in_valid_i),
        .byte_in_i       (byte_in_i),
        .byte_out_req_i  (byte_out_req_i),
        .rd_byte_i       (rd_byte),
        .head_i          (head_byte),
        .ptr_o           (ptr_q),
        .cfg_o           (cfg_q),
        .load_en_o       (load_en),
        .wr_en_o         (wr_en),
        .wr_idx_o        (wr_idx),
        .rd_idx_o        (rd_idx),
        .count_o         (count_q),
        .reading_o       (reading_q),
        .byte_out_o      (byte_out_o),
        .byte_out_valid_o(byte_out_valid_o)
    );

    pmbus_rsp_cmd_decode #(
        .FW_BYTES  (FW_BYTES),
        .FW_VERSION(FW_VERSION),
        .IDENT_CODE(IDENT_CODE)
    ) u_decode (
        .ptr_i       (ptr_q),
        .cfg_i       (cfg_q),
        .load_bytes_o(load_bytes),
        .load_len_o  (load_len)
    );

    pmbus_rsp_buffer #(.DEPTH(BUF_DEPTH)) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_bytes_i(load_bytes),
        .load_len_i  (load_len),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_data_i   (byte_in_i),
        .rd_idx_i    (rd_idx),
        .rd_byte_o   (rd_byte),
        .head_o      (head_byte)
    );

endmodule

// File: rtl/pmbus_rsp_checker.sv
// Property checker for the command responder, bound into the top module.
// Watches the ports together with the pointer, counter, open-read flag and configuration byte.
module pmbus_rsp_checker #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_write_i,
    input logic             start_read_i,
    input logic             close_i,
    input logic             byte_in_valid_i,
    input logic             byte_out_req_i,
    input logic [7:0]       byte_out_o,
    input logic             byte_out_valid_o,
    input logic [7:0]       ptr_q,
    input logic [7:0]       cfg_q,
    input logic [CNT_W-1:0] count_q,
    input logic             reading_q
);

    logic only_req;
    assign only_req = byte_out_req_i && !start_read_i && !start_write_i
                      && !close_i && !byte_in_valid_i;

    a_r4_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        only_req |=> byte_out_valid_o);

    a_r4_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
        byte_out_valid_o |-> $past(byte_out_req_i));

    a_r5_fill_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (only_req && count_q >= CNT_W'(DEPTH)) |=> (byte_out_o == 8'hFF));

    a_r11_fill_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (only_req && !reading_q) |=> (byte_out_o == 8'hFF));

    a_r11_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH + 1));

    a_r2_pointer_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_write_i || close_i) && !start_read_i) |=> (ptr_q == 8'hFF));

    a_r3_config_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_in_valid_i && ptr_q == 8'hDA) |=> $stable(cfg_q));

    a_r12_read_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start_read_i |=> (!byte_out_valid_o && count_q == '0 && reading_q));

endmodule

bind pmbus_psu_responder pmbus_rsp_checker #(.DEPTH(BUF_DEPTH)) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_write_i   (start_write_i),
    .start_read_i    (start_read_i),
    .close_i         (close_i),
    .byte_in_valid_i (byte_in_valid_i),
    .byte_out_req_i  (byte_out_req_i),
    .byte_out_o      (byte_out_o),
    .byte_out_valid_o(byte_out_valid_o),
    .ptr_q           (ptr_q),
    .cfg_q           (cfg_q),
    .count_q         (count_q),
    .reading_q       (reading_q)
);

// File: tb/test_pmbus_psu_responder.sv
// Bench: behavioural reference model compared on every clock, plus explicit
// expected bytes taken from the requirements.
module test_pmbus_psu_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_write_i = 1'b0;
    logic       start_read_i = 1'b0;
    logic       close_i = 1'b0;
    logic       byte_in_valid_i = 1'b0;
    logic [7:0] byte_in_i = 8'h00;
    logic       byte_out_req_i = 1'b0;
    logic [7:0] byte_out_o;
    logic       byte_out_valid_o;

    always #5 clk = ~clk;

    pmbus_psu_responder i_pmbus_psu_responder (
        .clk(clk), .rst_n(rst_n),
        .start_write_i(start_write_i), .start_read_i(start_read_i), .close_i(close_i),
        .byte_in_valid_i(byte_in_valid_i), .byte_in_i(byte_in_i),
        .byte_out_req_i(byte_out_req_i),
        .byte_out_o(byte_out_o), .byte_out_valid_o(byte_out_valid_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    logic [7:0] m_buf [32];
    int         m_ptr;
    int         m_cnt;
    bit         m_reading;
    logic [7:0] m_cfg;
    bit         m_valid;
    logic [7:0] m_data;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        foreach (m_buf[i]) m_buf[i] = 8'h00;
        m_ptr = 8'hFF; m_cnt = 0; m_reading = 0; m_cfg = 8'h00;
        m_valid = 0; m_data = 8'h00;
    endfunction

    function automatic void model_load(input string s, input int n);
        m_buf[0] = 8'(n);
        for (int i = 0; i < n; i++) m_buf[i+1] = s[i];
    endfunction

    function automatic void model_apply(input bit sr, input bit sw, input bit st,
                                        input bit wv, input logic [7:0] wd, input bit rr);
        m_valid = 0;
        if (sr) begin
            m_reading = 1; m_cnt = 0;
            case (m_ptr)
                'h9A: model_load("FRU0123", 7);
                'h9B: model_load("PAR0123", 7);
                'h9E: model_load("XYZ012", 6);
                'hBD: begin m_buf[0] = 8'h2B; m_buf[1] = 8'h1D; end
                'hFA: m_buf[0] = 8'h04;
                'hFB: m_buf[0] = 8'h03;
                'hFC: m_buf[0] = 8'h02;
                'hFD: m_buf[0] = 8'h01;
                'hDA: m_buf[0] = m_cfg;
                default: m_buf[0] = 8'h00;
            endcase
        end else if (sw || st) begin
            m_ptr = 8'hFF; m_cnt = 0; m_reading = 0;
        end else if (wv) begin
            if (m_cnt == 0) m_ptr = wd;
            else begin
                if (m_cnt <= 32) m_buf[m_cnt-1] = wd;
                if (m_ptr == 'hDA) m_cfg = m_buf[0];
            end
            if (m_cnt < 33) m_cnt++;
        end else if (rr) begin
            m_valid = 1;
            if (m_reading && m_cnt < 32) begin m_data = m_buf[m_cnt]; m_cnt++; end
            else m_data = 8'hFF;
        end
    endfunction

    task automatic compare_outputs();
        check(byte_out_valid_o == m_valid, cur_tag, "answer valid", byte_out_valid_o, m_valid);
        if (m_valid) begin
            check(byte_out_o == m_data, cur_tag, "answer byte vs model", byte_out_o, m_data);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(byte_out_o == e, t, "answer byte", byte_out_o, e);
            end
        end
    endtask

    task automatic step(input bit sr, input bit sw, input bit st,
                        input bit wv, input logic [7:0] wd, input bit rr);
        @(negedge clk);
        compare_outputs();
        start_read_i = sr; start_write_i = sw; close_i = st;
        byte_in_valid_i = wv; byte_in_i = wd; byte_out_req_i = rr;
        model_apply(sr, sw, st, wv, wd, rr);
    endtask

    task automatic idle();               step(0, 0, 0, 0, 8'h00, 0); endtask
    task automatic wstart();             step(0, 1, 0, 0, 8'h00, 0); endtask
    task automatic rstart();             step(1, 0, 0, 0, 8'h00, 0); endtask
    task automatic finish_txn();         step(0, 0, 1, 0, 8'h00, 0); endtask
    task automatic send(input logic [7:0] d); step(0, 0, 0, 1, d, 0); endtask
    task automatic expect_rd(input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        step(0, 0, 0, 0, 8'h00, 1);
    endtask
    task automatic select_cmd(input logic [7:0] c);
        wstart(); send(c); rstart();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, no answer, pointer parked, read gives register 0xFF = 0
        cur_tag = "R1";
        idle();
        expect_rd(8'hFF, "R11 request with no read open");
        idle();
        rstart();
        expect_rd(8'h00, "R1 read after reset");
        finish_txn();

        // R6: string commands
        cur_tag = "R6";
        select_cmd(8'h9A);
        begin
            string s = "FRU0123";
            expect_rd(8'd7, "R6 model count");
            for (int i = 0; i < 7; i++) expect_rd(s[i], "R6 model text");
        end
        finish_txn();
        select_cmd(8'h9B);
        begin
            string s = "PAR0123";
            expect_rd(8'd7, "R6 revision count");
            for (int i = 0; i < 7; i++) expect_rd(s[i], "R6 revision text");
        end
        finish_txn();
        select_cmd(8'h9E);
        begin
            string s = "XYZ012";
            expect_rd(8'd6, "R6 serial count");
            for (int i = 0; i < 6; i++) expect_rd(s[i], "R6 serial text");
        end
        finish_txn();

        // R7: identity code
        cur_tag = "R7";
        select_cmd(8'hBD);
        expect_rd(8'h2B, "R7 identity high");
        expect_rd(8'h1D, "R7 identity low");
        finish_txn();

        // R8: firmware window
        cur_tag = "R8";
        select_cmd(8'hFA); expect_rd(8'h04, "R8 firmware 0xFA"); finish_txn();
        select_cmd(8'hFB); expect_rd(8'h03, "R8 firmware 0xFB"); finish_txn();
        select_cmd(8'hFC); expect_rd(8'h02, "R8 firmware 0xFC"); finish_txn();
        select_cmd(8'hFD); expect_rd(8'h01, "R8 firmware 0xFD"); finish_txn();

        // R9: history and plain registers
        cur_tag = "R9";
        select_cmd(8'hD6); expect_rd(8'h00, "R9 history"); finish_txn();
        select_cmd(8'h42); expect_rd(8'h00, "R9 plain register"); finish_txn();

        // R3: config write keeps the first data byte; other commands do not touch it
        cur_tag = "R3";
        wstart(); send(8'hDA); send(8'h5C); send(8'h11); finish_txn();
        select_cmd(8'hDA); expect_rd(8'h5C, "R3 config first byte"); finish_txn();
        wstart(); send(8'h20); send(8'h77); finish_txn();
        select_cmd(8'hDA); expect_rd(8'h5C, "R3 config unchanged by other command"); finish_txn();
        select_cmd(8'h20); expect_rd(8'h00, "R3 other command not stored"); finish_txn();

        // R10: leftovers behind a short response
        cur_tag = "R10";
        wstart(); send(8'h10);
        for (int k = 0; k < 5; k++) send(8'hA0 + 8'(k));
        finish_txn();
        select_cmd(8'hBD);
        expect_rd(8'h2B, "R10 loaded byte 0");
        expect_rd(8'h1D, "R10 loaded byte 1");
        expect_rd(8'hA2, "R10 leftover 2");
        expect_rd(8'hA3, "R10 leftover 3");
        expect_rd(8'hA4, "R10 leftover 4");
        finish_txn();

        // R11 then R5: long write, then a walk past the end of the buffer
        cur_tag = "R11";
        wstart(); send(8'hDA);
        for (int k = 0; k < 40; k++) send(8'h30 + 8'(k));
        finish_txn();
        select_cmd(8'hDA); expect_rd(8'h30, "R11 config after long write"); finish_txn();
        cur_tag = "R5";
        select_cmd(8'h00);
        expect_rd(8'h00, "R5 position 0");
        for (int k = 1; k < 32; k++) expect_rd(8'h30 + 8'(k), "R5 leftover position");
        expect_rd(8'hFF, "R5 position 32");
        expect_rd(8'hFF, "R5 position 33");
        finish_txn();
        cur_tag = "R11";
        expect_rd(8'hFF, "R11 request after close");

        // R2: close parks the pointer; the first byte after a write start becomes it
        cur_tag = "R2";
        wstart(); send(8'hDA); finish_txn(); rstart();
        expect_rd(8'h00, "R2 pointer parked after close");
        finish_txn();
        wstart(); send(8'hBD); rstart();
        expect_rd(8'h2B, "R2 pointer from first byte");
        finish_txn();

        // R12: priority between events in one cycle
        cur_tag = "R12";
        wstart(); send(8'hFB);
        step(1, 0, 0, 0, 8'h00, 1);          // read start beats request
        idle();
        expect_rd(8'h03, "R12 request dropped, stream starts at 0");
        step(0, 1, 0, 1, 8'hBD, 0);          // write start beats data byte
        rstart();
        expect_rd(8'h00, "R12 data byte dropped under write start");
        step(0, 0, 1, 0, 8'h00, 1);          // close beats request
        idle();
        expect_rd(8'hFF, "R12 request after close in same cycle ignored");

        idle(); idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule